// File: doc/BRIEF.md
# Golomb-Rice Stream Decoder with Raw Bypass

This block turns a packed bitstream back into fixed-width data words. The matching sender encodes each L-bit word as a variable-length code. A leading path bit selects the format. With the path bit set, the code holds a K-bit binary remainder followed by a unary quotient. With the path bit clear, the code holds the word's fields unchanged. Both formats end in a zero terminator. The codes are packed back to back into W-bit input words, so one input word may carry several codes, and a code may straddle two input words.

Input words arrive over a valid/ready handshake. They are appended to an internal bit buffer that keeps unread bits across word boundaries. Each cycle the decoder parses the code at the head of the buffer. If the code is complete and the output stage can take it, the decoder emits one L-bit word over a second valid/ready handshake. An input word flagged as the last of a stream marks the end. Whatever follows the final complete code in that word is padding and is discarded, and the final output word carries a last flag.

Top module: `grd_decoder`

## Requirements
- R1: While reset is asserted, out_valid and in_ready are 0. Within four clock cycles after reset is released, in_ready is 1, and out_valid and out_last are still 0.
- R2: The stream is read least significant bit of the first input word first. A code whose first bit is 1 is a compressed code. The next K bits are the remainder (LSB first), then a run of q ones, then a 0. The decoder emits q*2^K + r.
- R3: A code whose first bit is 0 is a raw code of L+2 bits. The next L bits are the data word, LSB first: the low K bits, then the high L-K bits. These are followed by one terminator bit. The decoder emits those L bits unchanged.
- R4: When one input word holds several complete codes, every one is emitted in stream order, at most one output word per cycle.
- R5: A code split across two input words is reassembled and emitted correctly. Once the buffer holds at least L+2 unread bits and the output stage is empty, an output word is presented on the next cycle.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_last and out_err stay unchanged.
- R7: in_ready is 0 when the buffer holds more than L+1 unread bits. It is also 0 from the cycle after a last-marked input word is accepted until that stream has been fully emitted.
- R8: Bits after the final complete code of a last-marked input word are discarded and produce no output. out_last is 1 on the final output word of the stream and on no other word. The next stream then decodes from a clean buffer.
- R9: A compressed code whose unary run reaches L-K+1 ones is a protocol error. The decoder emits one word with out_err=1 and out_data=0, consumes L+2 bits, and carries on with the following code.
- R10: The decoder reproduces, without change, any sequence of L-bit words from an encoder that uses the compressed form when q <= L-K and the raw form otherwise. This includes q=0, q=L-K and raw values up to 2^L-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can accept an input word |
| in_data | input | W | Packed stream bits, bit 0 first |
| in_last | input | 1 | Input word is the final word of a stream |
| out_valid | output | 1 | Decoded word valid |
| out_ready | input | 1 | Consumer accepts the decoded word |
| out_data | output | L | Decoded word |
| out_last | output | 1 | Decoded word is the final word of its stream |
| out_err | output | 1 | Decoded beat marks an over-long unary run |

## Verification
An input word accepted at a clock edge enters the buffer at that edge and is parsed in the following cycle. A code it completes can therefore appear on out_valid at the second edge after the input handshake, or later under backpressure. in_ready falls in the cycle that directly follows the acceptance of a last-marked word. The bench drives and samples on the falling edge. Outputs are read there, after every register on the path has settled. Each handshake is recorded in the half cycle before the rising edge that completes it. Results are compared in stream order rather than at fixed cycles, so random gaps on both sides do not change the expected sequence. The cycle-exact cases are checked at the falling edge that follows the relevant rising edge: the reset values, in_ready after the last word, and the absence of output once a stream has drained.

// File: rtl/grd_pkg.sv
package grd_pkg;

  // Meaning of the leading bit of every code.
  typedef enum logic {
    PATH_RAW    = 1'b0,
    PATH_PACKED = 1'b1
  } grd_path_e;

endpackage

// File: rtl/grd_rst_sync.sv
module grd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_ok = stage_q[1];

endmodule

// File: rtl/grd_parse.sv
module grd_parse
  import grd_pkg::*;
#(
  parameter int L   = 16,
  parameter int K   = 4,
  parameter int BUF = 33,
  parameter int CW  = 6
) (
  input  logic [BUF-1:0] bits,
  input  logic [CW-1:0]  cnt,
  output logic           ok,
  output logic           err,
  output logic [CW-1:0]  len,
  output logic [L-1:0]   word
);

  localparam int QMAX    = L - K;
  localparam int QW      = $clog2(QMAX + 1);
  localparam int CODEMAX = L + 2;

  logic          stop;
  logic          found;
  logic [QW-1:0] qv;
  logic [K-1:0]  rem;

  always_comb begin
    ok    = 1'b0;
    err   = 1'b0;
    len   = '0;
    word  = '0;
    stop  = 1'b0;
    found = 1'b0;
    qv    = '0;
    rem   = bits[1 +: K];
    if (cnt != '0) begin
      if (bits[0] == PATH_RAW) begin
        len  = CW'(CODEMAX);
        word = bits[1 +: L];
        ok   = (int'(cnt) >= CODEMAX);
      end else begin
        for (int j = 0; j <= QMAX; j++) begin
          if (!stop) begin
            if (int'(cnt) <= 1 + K + j) begin
              stop = 1'b1;
            end else if (!bits[1 + K + j]) begin
              stop  = 1'b1;
              found = 1'b1;
              qv    = QW'(j);
            end
          end
        end
        if (found) begin
          ok            = 1'b1;
          len           = CW'(K + 2) + CW'(qv);
          word[K-1:0]   = rem;
          word[K +: QW] = qv;
        end else if (!stop) begin
          ok  = 1'b1;
          err = 1'b1;
          len = CW'(CODEMAX);
        end
      end
    end
  end

endmodule

// File: rtl/grd_bitbuf.sv
module grd_bitbuf #(
  parameter int W   = 16,
  parameter int BUF = 33,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [W-1:0]   in_word,
  input  logic [CW-1:0]  drop_len,
  input  logic           flush,
  output logic [BUF-1:0] bits,
  output logic [CW-1:0]  cnt
);

  logic [BUF-1:0] bits_q, bits_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           en;

  always_comb begin
    bits_d = bits_q >> drop_len;
    cnt_d  = cnt_q - drop_len;
    if (flush) begin
      bits_d = '0;
      cnt_d  = '0;
    end
    if (take) begin
      bits_d = bits_d | (BUF'(in_word) << cnt_d);
      cnt_d  = cnt_d + CW'(W);
    end
    en = take | flush | (drop_len != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign bits = bits_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/grd_outreg.sv
module grd_outreg #(
  parameter int L = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [L-1:0] ld_word,
  input  logic         ld_last,
  input  logic         ld_err,
  input  logic         out_ready,
  output logic         free,
  output logic         out_valid,
  output logic [L-1:0] out_data,
  output logic         out_last,
  output logic         out_err
);

  logic         valid_q, valid_d;
  logic [L-1:0] data_q;
  logic         last_q, err_q;

  always_comb begin
    free    = !valid_q || out_ready;
    valid_d = load ? 1'b1 : (valid_q && !out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (load) begin
      data_q <= ld_word;
      last_q <= ld_last;
      err_q  <= ld_err;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_last  = last_q;
  assign out_err   = err_q;

endmodule

// File: rtl/grd_decoder.sv
module grd_decoder #(
  parameter int L = 16,
  parameter int K = 4,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [L-1:0] out_data,
  output logic         out_last,
  output logic         out_err
);

  localparam int CODEMAX = L + 2;
  localparam int BUF     = W + CODEMAX - 1;
  localparam int CW      = $clog2(BUF + 1);

  logic           rst_ok;
  logic [BUF-1:0] buf_bits;
  logic [CW-1:0]  buf_cnt;
  logic           ok_a, err_a;
  logic [CW-1:0]  len_a;
  logic [L-1:0]   word_a;
  logic [BUF-1:0] rest_bits;
  logic [CW-1:0]  rest_cnt;
  logic           ok_b;
  logic           unused_err_b;
  logic [CW-1:0]  unused_len_b;
  logic [L-1:0]   unused_word_b;
  logic           out_free;
  logic           fire, final_code, flush, take;
  logic [CW-1:0]  drop_len;
  logic           last_seen, last_seen_d;

  grd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  grd_bitbuf #(.W(W), .BUF(BUF), .CW(CW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .in_word  (in_data),
    .drop_len (drop_len),
    .flush    (flush),
    .bits     (buf_bits),
    .cnt      (buf_cnt)
  );

  grd_parse #(.L(L), .K(K), .BUF(BUF), .CW(CW)) u_head (
    .bits (buf_bits),
    .cnt  (buf_cnt),
    .ok   (ok_a),
    .err  (err_a),
    .len  (len_a),
    .word (word_a)
  );

  assign rest_bits = buf_bits >> len_a;
  assign rest_cnt  = buf_cnt - len_a;

  grd_parse #(.L(L), .K(K), .BUF(BUF), .CW(CW)) u_next (
    .bits (rest_bits),
    .cnt  (rest_cnt),
    .ok   (ok_b),
    .err  (unused_err_b),
    .len  (unused_len_b),
    .word (unused_word_b)
  );

  always_comb begin
    fire        = ok_a && out_free;
    final_code  = last_seen && !ok_b;
    flush       = last_seen && ((fire && final_code) || !ok_a);
    drop_len    = fire ? len_a : '0;
    in_ready    = rst_ok && !last_seen && (int'(buf_cnt) <= BUF - W);
    take        = in_valid && in_ready;
    last_seen_d = last_seen;
    if (take && in_last) begin
      last_seen_d = 1'b1;
    end else if (flush) begin
      last_seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_seen <= 1'b0;
    end else begin
      last_seen <= last_seen_d;
    end
  end

  grd_outreg #(.L(L)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .ld_word   (word_a),
    .ld_last   (final_code),
    .ld_err    (err_a),
    .out_ready (out_ready),
    .free      (out_free),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_err   (out_err)
  );

endmodule

// File: rtl/grd_decoder_sva.sv
module grd_decoder_sva #(
  parameter int L = 16,
  parameter int K = 4,
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [L-1:0] out_data,
  input logic         out_last,
  input logic         out_err,
  input logic [$clog2(W + L + 2):0] cnt
);

  localparam int CODEMAX = L + 2;
  localparam int BUF     = W + CODEMAX - 1;

  // R6: a stalled output beat does not move
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_last) && $stable(out_err)));

  // R7: the buffer never holds more bits than it was sized for
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= BUF);

  // R7: input closes right after a last-marked word is taken
  p_close_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R5: a full-length window of bits always yields an output next cycle
  p_code_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) >= CODEMAX && !out_valid) |=> out_valid);

  // R9: an error beat carries an all-zero word
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));

endmodule

bind grd_decoder grd_decoder_sva #(.L(L), .K(K), .W(W)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_err   (out_err),
  .cnt       (buf_cnt)
);

// File: tb/grd_decoder_tb.sv
module grd_decoder_tb_top;

  localparam int L    = 16;
  localparam int K    = 4;
  localparam int W    = 16;
  localparam int QMAX = L - K;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_data;
  logic         in_last;
  logic         out_valid;
  logic         out_ready;
  logic [L-1:0] out_data;
  logic         out_last;
  logic         out_err;

  int n_checks;
  int n_fail;

  logic         sbits [0:8191];
  int           nb;
  logic [W-1:0] w_arr [0:1023];
  int           w_n;
  logic [L-1:0] exp_d [0:1023];
  logic         exp_e [0:1023];
  int           exp_n;

  grd_decoder #(.L(L), .K(K), .W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_err   (out_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic good, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic b);
    sbits[nb] = b;
    nb++;
  endtask

  task automatic start_stream();
    nb    = 0;
    exp_n = 0;
  endtask

  // Reference encoder built from R2 and R3
  task automatic enc(input logic [L-1:0] v);
    int q;
    q = int'(v) >> K;
    if (q <= QMAX) begin
      put(1'b1);
      for (int i = 0; i < K; i++) put(v[i]);
      for (int i = 0; i < q; i++) put(1'b1);
      put(1'b0);
    end else begin
      put(1'b0);
      for (int i = 0; i < L; i++) put(v[i]);
      put(1'b0);
    end
    exp_d[exp_n] = v;
    exp_e[exp_n] = 1'b0;
    exp_n++;
  endtask

  task automatic pack();
    w_n = (nb + W - 1) / W;
    for (int wi = 0; wi < w_n; wi++) begin
      for (int b = 0; b < W; b++) begin
        w_arr[wi][b] = (wi * W + b < nb) ? sbits[wi * W + b] : 1'b0;
      end
    end
  endtask

  task automatic drive();
    int  idx;
    logic sent;
    idx = 0;
    while (idx < w_n) begin
      in_valid = ($urandom % 5) != 0;
      in_data  = w_arr[idx];
      in_last  = (idx == w_n - 1);
      sent     = in_valid && in_ready;
      @(negedge clk);
      if (sent) begin
        if (idx == w_n - 1) begin
          // R7: closed one cycle after the last word is taken
          chk(in_ready == 1'b0, "R7", "in_ready after last", in_ready, 0);
        end
        idx++;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic receive(input string req);
    int got;
    int t;
    logic [L-1:0] ev;
    got = 0;
    t   = 0;
    while (got < exp_n && t < 20000) begin
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        ev = exp_d[got];
        chk(out_data == ev, req, "data", out_data, ev);
        chk(out_err == exp_e[got], "R9", "err flag", out_err, exp_e[got]);
        // R8: last only on the final word of the stream
        chk(out_last == (got == exp_n - 1), "R8", "last flag", out_last,
            (got == exp_n - 1));
        got++;
      end
      @(negedge clk);
      t++;
    end
    chk(got == exp_n, req, "word count", got, exp_n);
  endtask

  task automatic run_stream(input string req);
    int extra;
    pack();
    fork
      drive();
      receive(req);
    join
    out_ready = 1'b1;
    extra     = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    // R8: padding yields no output
    chk(extra == 0, "R8", "beats after stream end", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [L-1:0] v;
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    in_last   = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_last == 1'b0, "R1", "out_last after reset", out_last, 0);

    // R2 R4 R5 R10: every quotient 0..QMAX with several remainders, then raw words
    start_stream();
    for (int q = 0; q <= QMAX; q++) begin
      enc(L'(q * 16 + 0));
      enc(L'(q * 16 + 5));
      enc(L'(q * 16 + 15));
    end
    enc(16'd208);
    enc(16'hFFFF);
    enc(16'h8000);
    enc(16'h1234);
    enc(16'd0);
    run_stream("R2");

    // R4: one short code alone in a single word, last on it
    start_stream();
    enc(16'd7);
    run_stream("R4");

    // R3 R5: one raw code spanning two words
    start_stream();
    enc(16'hA5C3);
    run_stream("R3");

    // R9: over-long unary run, then a normal code
    start_stream();
    put(1'b1);
    for (int i = 0; i < K; i++) put(1'b1);
    for (int i = 0; i <= QMAX; i++) put(1'b1);
    exp_d[0] = '0;
    exp_e[0] = 1'b1;
    exp_n    = 1;
    enc(16'h0025);
    run_stream("R9");

    // R10 R5: random mix of compressible and raw words
    start_stream();
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2 == 0) v = L'($urandom_range(0, (QMAX + 1) * 16 - 1));
      else v = L'($urandom);
      enc(v);
    end
    run_stream("R10");

    // R3 R8: back-to-back raw stream after the previous one
    start_stream();
    enc(16'hFFFF);
    enc(16'h0F00);
    enc(16'd1);
    run_stream("R3");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule